// File: doc/BRIEF.md
# Reset Classifier with Boot Latch

This block sits at the reset input of a chip. It watches two active-low reset lines: a system reset and a test reset. Each reset event is classified as cold (power-on) or warm, and the class sets what the chip keeps. A cold reset asks for internal memory to be cleared and opens a capture of the boot-mode strap pins. A warm reset leaves memory alone and keeps the boot mode captured at the last cold reset.

Both reset lines pass through short synchronizers, so assertion takes effect at once and release is seen on clock edges. While the system reset is held, the reset class is re-sampled every cycle. The class seen on the last cycle before release decides what the release does. On a cold release the strap pins are written into the boot-mode register on the same edge that raises the core-release output. Software reading the mode therefore always sees a settled value. The test reset line acts as the power domain's reset for the persistent state: whenever it is low, the boot-mode register and its valid flag are cleared.

Top module: `reset_kind_latch`

## Requirements
- R1: While `sys_rst_n` and `tst_rst_n` are both low, `mem_clear` is 1 with no clock edge needed.
- R2: While `sys_rst_n` is low and `tst_rst_n` has been high for at least two clock edges, `mem_clear` is 0. It is also 0 whenever the block runs (`core_release` = 1).
- R3: `core_release` drops to 0 as soon as `sys_rst_n` goes low and stays 0 while it is low. After `sys_rst_n` rises, `core_release` stays 0 through the next two rising edges and becomes 1 on the third.
- R4: On a cold release, `boot_mode` takes the value `boot_pins` had at the third rising edge after release, and `mode_valid` becomes 1. Both are visible in the same cycle that `core_release` first reads 1.
- R5: On a warm release, `boot_mode` and `mode_valid` keep their values, both during the warm reset and after it.
- R6: The class of a release is the class seen on the last cycle before release, after synchronization. A reset that starts warm and turns cold before release latches the pins. A reset that starts cold and turns warm before release does not latch them.
- R7: While `tst_rst_n` is low, `boot_mode` reads all zeros and `mode_valid` reads 0. Before any cold release, both stay at these values.
- R8: After release, `cold_flag` reads 1 if the release was cold and 0 if it was warm. It holds that value while the block runs.
- R9: While the block runs, changes on `boot_pins` have no effect on `boot_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous assertion |
| tst_rst_n | input | 1 | Test reset, active low; low together with the system reset marks a cold reset |
| boot_pins | input | BOOT_W | Boot-mode strap pins |
| boot_mode | output | BOOT_W | Boot mode captured at the last cold release |
| mode_valid | output | 1 | 1 once a cold release has captured the boot mode |
| cold_flag | output | 1 | Class of the last reset: 1 cold, 0 warm |
| mem_clear | output | 1 | Request to clear internal memory during a cold reset |
| core_release | output | 1 | 1 when the core may leave reset |

## Verification
The main function is tried with a sequence of cold and warm resets in mixed order. Each reset uses a distinct strap pattern, so a warm release that wrongly captured the pins would show a different `boot_mode`. Back-to-back warm resets, and cold after cold, separate "keep the last cold value" from "keep the previous value". A first reset that is warm from power-up separates the cleared state from a captured all-zero pattern. Resets whose class changes while the system reset is held show whether the last cycle, and not the first, decides the class. Toggling the straps while the block runs shows that capture happens only at release.

// File: rtl/rkl_pkg.sv
package rkl_pkg;

  typedef enum logic {
    RK_WARM = 1'b0,
    RK_COLD = 1'b1
  } rst_kind_e;

  // Class of an ongoing reset, given the synchronized test reset level.
  function automatic rst_kind_e kind_of(input logic tst_ok);
    return tst_ok ? RK_WARM : RK_COLD;
  endfunction

  // Memory clear is wanted only while both synchronized resets are active.
  function automatic logic clear_req(input logic sys_ok, input logic tst_ok);
    return !sys_ok && !tst_ok;
  endfunction

  // Capture happens on a release whose final class was cold.
  function automatic logic capture_now(input logic release_evt, input rst_kind_e kind);
    return release_evt && (kind == RK_COLD);
  endfunction

endpackage

// File: rtl/rkl_sync.sv
// Reset synchronizer: asynchronous assertion, release after STAGES edges.
module rkl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_n,
  output logic sync_ok
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge async_n) begin
        if (!async_n) chain_q <= '0;
        else          chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge async_n) begin
        if (!async_n) chain_q <= '0;
        else          chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign sync_ok = chain_q[LAST];
endmodule

// File: rtl/rkl_kind_track.sv
// Tracks the class of the current reset and produces the release event.
module rkl_kind_track
  import rkl_pkg::*;
(
  input  logic      clk,
  input  logic      sys_arst_n,
  input  logic      pwr_arst_n,
  input  logic      sys_ok,
  input  logic      tst_ok,
  output rst_kind_e kind_q,
  output logic      release_evt,
  output logic      run_q
);
  // Re-sampled every cycle of a system reset; frozen while running.
  always_ff @(posedge clk or negedge pwr_arst_n) begin
    if (!pwr_arst_n)  kind_q <= RK_COLD;
    else if (!sys_ok) kind_q <= kind_of(tst_ok);
  end

  // One cycle behind the synchronized system reset; doubles as core release.
  always_ff @(posedge clk or negedge sys_arst_n) begin
    if (!sys_arst_n) run_q <= 1'b0;
    else             run_q <= sys_ok;
  end

  assign release_evt = sys_ok && !run_q;
endmodule

// File: rtl/rkl_boot_latch.sv
// Boot-mode capture register, cleared only by the power-domain reset.
module rkl_boot_latch #(
  parameter int BOOT_W = 8
) (
  input  logic              clk,
  input  logic              pwr_arst_n,
  input  logic              load,
  input  logic [BOOT_W-1:0] pins,
  output logic [BOOT_W-1:0] mode_q,
  output logic              valid_q
);
  always_ff @(posedge clk or negedge pwr_arst_n) begin
    if (!pwr_arst_n) begin
      mode_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      mode_q  <= pins;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/reset_kind_latch.sv
module reset_kind_latch
  import rkl_pkg::*;
#(
  parameter int BOOT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              tst_rst_n,
  input  logic [BOOT_W-1:0] boot_pins,
  output logic [BOOT_W-1:0] boot_mode,
  output logic              mode_valid,
  output logic              cold_flag,
  output logic              mem_clear,
  output logic              core_release
);
  // Named internal events, brought out for the checker.
  logic      sys_ok;
  logic      tst_ok;
  logic      release_evt;
  logic      capture_evt;
  logic      run_q;
  rst_kind_e kind_q;

  rkl_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk     (clk),
    .async_n (sys_rst_n),
    .sync_ok (sys_ok)
  );

  rkl_sync #(.STAGES(SYNC_STAGES)) u_tst_sync (
    .clk     (clk),
    .async_n (tst_rst_n),
    .sync_ok (tst_ok)
  );

  rkl_kind_track u_kind (
    .clk         (clk),
    .sys_arst_n  (sys_rst_n),
    .pwr_arst_n  (tst_rst_n),
    .sys_ok      (sys_ok),
    .tst_ok      (tst_ok),
    .kind_q      (kind_q),
    .release_evt (release_evt),
    .run_q       (run_q)
  );

  assign capture_evt = capture_now(release_evt, kind_q);

  rkl_boot_latch #(.BOOT_W(BOOT_W)) u_latch (
    .clk        (clk),
    .pwr_arst_n (tst_rst_n),
    .load       (capture_evt),
    .pins       (boot_pins),
    .mode_q     (boot_mode),
    .valid_q    (mode_valid)
  );

  assign cold_flag    = (kind_q == RK_COLD);
  assign mem_clear    = clear_req(sys_ok, tst_ok);
  assign core_release = run_q;
endmodule

// File: rtl/rkl_checker.sv
module rkl_checker #(
  parameter int BOOT_W = 8
) (
  input logic              clk,
  input logic              sys_rst_n,
  input logic              tst_rst_n,
  input logic [BOOT_W-1:0] boot_pins,
  input logic [BOOT_W-1:0] boot_mode,
  input logic              mode_valid,
  input logic              cold_flag,
  input logic              mem_clear,
  input logic              core_release
);
  // R3
  core_held_chk: assert property (@(posedge clk) disable iff (!tst_rst_n)
    !sys_rst_n |-> !core_release);

  // R2
  no_clear_running_chk: assert property (@(posedge clk) disable iff (!tst_rst_n)
    core_release |-> !mem_clear);

  // R4
  cold_capture_chk: assert property (@(posedge clk) disable iff (!tst_rst_n)
    ($rose(core_release) && cold_flag) |-> (mode_valid && boot_mode == $past(boot_pins)));

  // R5
  warm_keep_chk: assert property (@(posedge clk) disable iff (!tst_rst_n)
    ($rose(core_release) && !cold_flag) |-> ($stable(boot_mode) && $stable(mode_valid)));

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!tst_rst_n)
    mode_valid |=> mode_valid);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!tst_rst_n)
    (core_release && $past(core_release)) |-> $stable(cold_flag));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!tst_rst_n)
    (core_release && $past(core_release)) |-> $stable(boot_mode));
endmodule

bind reset_kind_latch rkl_checker #(.BOOT_W(BOOT_W)) u_rkl_chk (
  .clk          (clk),
  .sys_rst_n    (sys_rst_n),
  .tst_rst_n    (tst_rst_n),
  .boot_pins    (boot_pins),
  .boot_mode    (boot_mode),
  .mode_valid   (mode_valid),
  .cold_flag    (cold_flag),
  .mem_clear    (mem_clear),
  .core_release (core_release)
);

// File: tb/tb_reset_kind_latch.sv
module tb_reset_kind_latch;
  localparam int BOOT_W = 8;
  localparam int NVEC   = 8;
  localparam int WATCHDOG_CYC = 200000;

  logic              clk = 1'b0;
  logic              sys_rst_n;
  logic              tst_rst_n;
  logic [BOOT_W-1:0] boot_pins;
  logic [BOOT_W-1:0] boot_mode;
  logic              mode_valid, cold_flag, mem_clear, core_release;

  int n_chk  = 0;
  int n_fail = 0;

  logic [BOOT_W-1:0] exp_mode  = '0;
  logic              exp_valid = 1'b0;

  // {test reset level held during the reset, strap pattern}
  localparam logic [BOOT_W:0] VEC [NVEC] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b1, 8'hFF}, {1'b0, 8'h00},
    {1'b0, 8'h5A}, {1'b1, 8'h81}, {1'b0, 8'hC3}, {1'b1, 8'h7E}
  };

  always #4 clk = ~clk;

  reset_kind_latch #(.BOOT_W(BOOT_W)) dut (
    .clk          (clk),
    .sys_rst_n    (sys_rst_n),
    .tst_rst_n    (tst_rst_n),
    .boot_pins    (boot_pins),
    .boot_mode    (boot_mode),
    .mode_valid   (mode_valid),
    .cold_flag    (cold_flag),
    .mem_clear    (mem_clear),
    .core_release (core_release)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Release both lines together at a negedge and check the release timing.
  task automatic release_and_check(input logic was_cold);
    sys_rst_n = 1'b1;
    tst_rst_n = 1'b1;
    @(negedge clk);
    chk("R3 core low after edge 1", {31'd0, core_release}, 32'd0);
    @(negedge clk);
    chk("R3 core low after edge 2", {31'd0, core_release}, 32'd0);
    @(negedge clk);
    chk("R3 core high after edge 3", {31'd0, core_release}, 32'd1);
    if (was_cold) begin
      exp_mode  = boot_pins;
      exp_valid = 1'b1;
    end
    chk(was_cold ? "R4 mode after cold" : "R5 mode after warm", {24'd0, boot_mode}, {24'd0, exp_mode});
    chk(was_cold ? "R4 valid after cold" : "R5 valid after warm", {31'd0, mode_valid}, {31'd0, exp_valid});
    chk("R8 cold_flag", {31'd0, cold_flag}, {31'd0, was_cold});
    chk("R2 no clear while running", {31'd0, mem_clear}, 32'd0);
  endtask

  task automatic run_reset(input logic tst_lvl, input logic [BOOT_W-1:0] pins);
    @(negedge clk);
    boot_pins = pins;
    tst_rst_n = tst_lvl;
    sys_rst_n = 1'b0;
    #1;
    chk("R3 core drops at once", {31'd0, core_release}, 32'd0);
    if (!tst_lvl) begin
      chk("R1 clear at once", {31'd0, mem_clear}, 32'd1);
      exp_mode  = '0;
      exp_valid = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(tst_lvl ? "R2 no clear in warm" : "R1 clear in cold", {31'd0, mem_clear}, {31'd0, !tst_lvl});
    chk("R3 core held", {31'd0, core_release}, 32'd0);
    chk(tst_lvl ? "R5 mode kept in warm" : "R7 mode cleared in cold", {24'd0, boot_mode}, {24'd0, exp_mode});
    chk(tst_lvl ? "R5 valid kept in warm" : "R7 valid cleared in cold", {31'd0, mode_valid}, {31'd0, exp_valid});
    release_and_check(!tst_lvl);
    boot_pins = ~pins;
    repeat (3) @(negedge clk);
    chk("R9 straps ignored while running", {24'd0, boot_mode}, {24'd0, exp_mode});
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    sys_rst_n = 1'b0;
    tst_rst_n = 1'b0;
    boot_pins = 8'h99;
    repeat (3) @(negedge clk);
    // Power-up: both resets low.
    chk("R7 mode zero at power-up", {24'd0, boot_mode}, 32'd0);
    chk("R7 valid low at power-up", {31'd0, mode_valid}, 32'd0);
    chk("R1 clear at power-up", {31'd0, mem_clear}, 32'd1);
    chk("R3 core low at power-up", {31'd0, core_release}, 32'd0);
    // The first release is warm: the test reset rises well before the system reset.
    tst_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 clear drops when warm", {31'd0, mem_clear}, 32'd0);
    sys_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 mode zero before any cold release", {24'd0, boot_mode}, 32'd0);
    chk("R7 valid low before any cold release", {31'd0, mode_valid}, 32'd0);
    chk("R8 first release warm", {31'd0, cold_flag}, 32'd0);
    chk("R3 core released", {31'd0, core_release}, 32'd1);

    // Table of mixed cold and warm resets.
    for (int i = 0; i < NVEC; i++) begin
      run_reset(VEC[i][BOOT_W], VEC[i][BOOT_W-1:0]);
    end

    // R6: a reset that starts warm and turns cold before release captures the straps.
    @(negedge clk);
    boot_pins = 8'h6E;
    sys_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 warm phase no clear", {31'd0, mem_clear}, 32'd0);
    tst_rst_n = 1'b0;
    exp_mode  = '0;
    exp_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 cold phase clear", {31'd0, mem_clear}, 32'd1);
    release_and_check(1'b1);
    chk("R6 warm-then-cold captured", {24'd0, boot_mode}, 32'h6E);

    // R6: a reset that starts cold and turns warm before release does not capture.
    @(negedge clk);
    boot_pins = 8'h17;
    sys_rst_n = 1'b0;
    tst_rst_n = 1'b0;
    exp_mode  = '0;
    exp_valid = 1'b0;
    repeat (3) @(negedge clk);
    tst_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 clear gone once warm", {31'd0, mem_clear}, 32'd0);
    release_and_check(1'b0);
    chk("R6 cold-then-warm not captured", {24'd0, boot_mode}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule